// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block is the coherence controller of one direct-mapped, write-back cache that shares an atomic bus with peer caches and a memory. Each line is held in one of three states: invalid, shared (a clean, read-only copy) or exclusive (the only copy, dirty and writable). Processor reads and writes that hit complete without touching the bus. Misses arbitrate for the bus and issue a read-miss or write-miss command. A dirty victim of another address is first written back with a write-back command.

Every command on the bus is also snooped. When a peer misses on a block that this cache holds dirty, the controller raises an abort line so that memory does not answer. It then drives the dirty data, which both the requester and memory take in the same bus cycle. A snooped read miss demotes the line to shared. A snooped write miss invalidates the line.

A bus transaction takes exactly one granted cycle. The bus fabric outside the block grants the bus, merges the drivers and selects the fill data: it uses the aborting cache's data when an abort is raised and memory data otherwise.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address is a miss that goes to the bus, and no bus request or command is active.
- R2: A processor read that misses issues a read-miss command (code 1), fills the line from the bus data and leaves it shared. A later read hit, in shared or exclusive, completes with no bus command.
- R3: A processor write to an invalid line, or to a shared line, issues a write-miss command (code 2) and leaves the line exclusive with the written data. A write hit on an exclusive line completes with no bus command.
- R4: A miss whose line holds a different address in the exclusive state first issues a write-back command (code 3) that carries the old address and data. The read or write miss follows it.
- R5: A miss whose line holds a different address in the shared state issues only the read or write miss, with no write-back.
- R6: A peer read miss to an address held exclusive raises the abort output and drives the line data on the snoop data output in that cycle. The line becomes shared and keeps its data.
- R7: A peer write miss to a held address makes the line invalid. If the line was exclusive, the abort output and its data are driven in that cycle. If it was shared, no abort is raised.
- R8: During any cycle in which a peer read or write miss targets the same line index as the pending processor access, the processor access does not complete. The snoop update wins, and the access is retried on a later cycle.
- R9: The controller raises its bus request while it needs the bus. It drives a command only in a cycle in which the grant is high, and the command carries its own requester id. Command code 0 means no command.
- R10: Write-back commands on the bus, and commands that carry this cache's own id, never cause an abort or a change of line state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access pending; held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_done is high |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for this cycle |
| bus_cmd | output | 2 | Command driven: 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the driven command, 0 when idle |
| bus_wdata | output | DATA_W | Write-back data, 0 otherwise |
| bus_id | output | ID_W | Requester id of the driven command, 0 when idle |
| bus_rdata | input | DATA_W | Fill data presented by the bus during a miss |
| snp_cmd | input | 2 | Command currently on the bus |
| snp_addr | input | ADDR_W | Address currently on the bus |
| snp_id | input | ID_W | Requester id currently on the bus |
| snp_abort | output | 1 | Memory access aborted; this cache supplies the block |
| snp_data | output | DATA_W | Dirty block supplied with snp_abort, 0 otherwise |

## Verification
The assertions assume that the bus fabric grants at most one cache per cycle. They also assume that the snoop inputs carry the merged bus, so a controller sees its own commands with its own id. Finally, they assume that the processor holds cpu_we, cpu_addr and cpu_wdata steady from the request until cpu_done. The bench meets these assumptions with a fixed-priority arbiter, an OR of the drivers that are zero when idle, and access tasks that change processor inputs only after a completion. Line states are never read directly. The bench infers them from the commands, aborts, memory contents and read data observed on the bus.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2
   } ln_state_t;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_RDMISS = 2'd1,
      CMD_WRMISS = 2'd2,
      CMD_WBACK  = 2'd3
   } bus_cmd_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
   import msi_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor-side read port
   input  logic [IDX_W-1:0]  a_idx,
   output ln_state_t         a_st,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   // snoop-side read port
   input  logic [IDX_W-1:0]  s_idx,
   output ln_state_t         s_st,
   output logic [TAG_W-1:0]  s_tag,
   output logic [DATA_W-1:0] s_data,
   // full-line write (fill or processor write hit)
   input  logic              w_en,
   input  logic [IDX_W-1:0]  w_idx,
   input  ln_state_t         w_st,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [DATA_W-1:0] w_data,
   // state-only write from the snoop side
   input  logic              u_en,
   input  logic [IDX_W-1:0]  u_idx,
   input  ln_state_t         u_st
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0][1:0]        st_vec;
   logic [LINES-1:0][TAG_W-1:0]  tag_vec;
   logic [LINES-1:0][DATA_W-1:0] dat_vec;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      ln_state_t         st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LN_INV;
            tag_q <= '0;
            dat_q <= '0;
         end else begin
            if (w_en && (w_idx == IDX_W'(i))) begin
               st_q  <= w_st;
               tag_q <= w_tag;
               dat_q <= w_data;
            end
            if (u_en && (u_idx == IDX_W'(i))) begin
               st_q <= u_st;
            end
         end
      end

      assign st_vec[i]  = st_q;
      assign tag_vec[i] = tag_q;
      assign dat_vec[i] = dat_q;
   end

   assign a_st   = ln_state_t'(st_vec[a_idx]);
   assign a_tag  = tag_vec[a_idx];
   assign a_data = dat_vec[a_idx];
   assign s_st   = ln_state_t'(st_vec[s_idx]);
   assign s_tag  = tag_vec[s_idx];
   assign s_data = dat_vec[s_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
   import msi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8,
   parameter int ID_W   = 1,
   parameter int MY_ID  = 0
) (
   input  bus_cmd_t          snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [ID_W-1:0]   snp_id,
   input  ln_state_t         line_st,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   output logic              peer_miss,
   output logic              upd_en,
   output ln_state_t         upd_st,
   output logic              abort,
   output logic [DATA_W-1:0] flush_data
);
   logic foreign;
   logic holds;

   assign foreign   = (snp_id != ID_W'(MY_ID));
   assign holds     = foreign && (line_st != LN_INV) && (line_tag == snp_tag);
   assign peer_miss = foreign && ((snp_cmd == CMD_RDMISS) || (snp_cmd == CMD_WRMISS));

   always_comb begin
      upd_en     = 1'b0;
      upd_st     = line_st;
      abort      = 1'b0;
      flush_data = '0;
      unique case (snp_cmd)
         CMD_RDMISS: begin
            if (holds && (line_st == LN_EXC)) begin
               upd_en     = 1'b1;
               upd_st     = LN_SHR;
               abort      = 1'b1;
               flush_data = line_data;
            end
         end
         CMD_WRMISS: begin
            if (holds) begin
               upd_en = 1'b1;
               upd_st = LN_INV;
               if (line_st == LN_EXC) begin
                  abort      = 1'b1;
                  flush_data = line_data;
               end
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
   import msi_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [TAG_W-1:0]       cpu_tag,
   input  logic [IDX_W-1:0]       cpu_idx,
   input  ln_state_t              line_st,
   input  logic [TAG_W-1:0]       line_tag,
   input  logic                   stall,
   input  logic                   bus_gnt,
   output logic                   done,
   output logic                   bus_req,
   output bus_cmd_t               cmd,
   output logic [TAG_W+IDX_W-1:0] cmd_addr,
   output logic                   fill_en,
   output ln_state_t              fill_st
);
   typedef enum logic [1:0] {RQ_IDLE, RQ_WBACK, RQ_FETCH} rq_state_t;

   rq_state_t cur_q, nxt;
   logic      tag_eq, hit, victim_dirty;

   assign tag_eq       = (line_tag == cpu_tag);
   assign hit          = (line_st != LN_INV) && tag_eq && (!cpu_we || (line_st == LN_EXC));
   assign victim_dirty = (line_st == LN_EXC) && !tag_eq;

   always_comb begin
      nxt      = cur_q;
      done     = 1'b0;
      bus_req  = 1'b0;
      cmd      = CMD_NONE;
      cmd_addr = '0;
      fill_en  = 1'b0;
      fill_st  = LN_INV;
      unique case (cur_q)
         RQ_IDLE: begin
            if (cpu_req && !stall) begin
               if (hit)               done = 1'b1;
               else if (victim_dirty) nxt  = RQ_WBACK;
               else                   nxt  = RQ_FETCH;
            end
         end
         RQ_WBACK: begin
            // a snoop may already have taken the dirty victim away
            if (!victim_dirty) begin
               nxt = RQ_FETCH;
            end else begin
               bus_req = 1'b1;
               if (bus_gnt) begin
                  cmd      = CMD_WBACK;
                  cmd_addr = {line_tag, cpu_idx};
                  nxt      = RQ_FETCH;
               end
            end
         end
         RQ_FETCH: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               cmd      = cpu_we ? CMD_WRMISS : CMD_RDMISS;
               cmd_addr = {cpu_tag, cpu_idx};
               fill_en  = 1'b1;
               fill_st  = cpu_we ? LN_EXC : LN_SHR;
               nxt      = RQ_IDLE;
            end
         end
         default: nxt = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= RQ_IDLE;
      else        cur_q <= nxt;
   end
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
   import msi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2,
   parameter int ID_W   = 1,
   parameter int MY_ID  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [ID_W-1:0]   bus_id,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [ID_W-1:0]   snp_id,
   output logic              snp_abort,
   output logic [DATA_W-1:0] snp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("IDX_W must lie between 1 and ADDR_W-1");
   end
   if (ID_W < 1 || MY_ID < 0 || MY_ID >= (1 << ID_W)) begin : g_bad_id
      $error("MY_ID does not fit in ID_W bits");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   logic [TAG_W-1:0]  cpu_tag, snp_tag;
   ln_state_t         a_st, s_st, upd_st, fill_st;
   logic [TAG_W-1:0]  a_tag, s_tag;
   logic [DATA_W-1:0] a_data, s_data;
   logic              peer_miss, upd_en, stall, fill_en, w_en;
   bus_cmd_t          cmd;
   ln_state_t         w_st;
   logic [DATA_W-1:0] w_data;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

   // the snoop side owns the index for this cycle
   assign stall = peer_miss && (snp_idx == cpu_idx);

   assign w_en   = fill_en || (cpu_done && cpu_we);
   assign w_st   = fill_en ? fill_st : LN_EXC;
   assign w_data = fill_en ? bus_rdata : cpu_wdata;

   msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_idx  (cpu_idx),
      .a_st   (a_st),
      .a_tag  (a_tag),
      .a_data (a_data),
      .s_idx  (snp_idx),
      .s_st   (s_st),
      .s_tag  (s_tag),
      .s_data (s_data),
      .w_en   (w_en),
      .w_idx  (cpu_idx),
      .w_st   (w_st),
      .w_tag  (cpu_tag),
      .w_data (w_data),
      .u_en   (upd_en),
      .u_idx  (snp_idx),
      .u_st   (upd_st)
   );

   msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
      .snp_cmd    (bus_cmd_t'(snp_cmd)),
      .snp_tag    (snp_tag),
      .snp_id     (snp_id),
      .line_st    (s_st),
      .line_tag   (s_tag),
      .line_data  (s_data),
      .peer_miss  (peer_miss),
      .upd_en     (upd_en),
      .upd_st     (upd_st),
      .abort      (snp_abort),
      .flush_data (snp_data)
   );

   msi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_req  (cpu_req),
      .cpu_we   (cpu_we),
      .cpu_tag  (cpu_tag),
      .cpu_idx  (cpu_idx),
      .line_st  (a_st),
      .line_tag (a_tag),
      .stall    (stall),
      .bus_gnt  (bus_gnt),
      .done     (cpu_done),
      .bus_req  (bus_req),
      .cmd      (cmd),
      .cmd_addr (bus_addr),
      .fill_en  (fill_en),
      .fill_st  (fill_st)
   );

   assign bus_cmd   = cmd;
   assign bus_wdata = (cmd == CMD_WBACK) ? a_data : '0;
   assign bus_id    = (cmd != CMD_NONE) ? ID_W'(MY_ID) : '0;
   assign cpu_rdata = a_data;
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int ID_W   = 1,
   parameter int MY_ID  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_done,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic [ID_W-1:0]   bus_id,
   input logic [1:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic [ID_W-1:0]   snp_id,
   input logic              snp_abort,
   input logic [1:0]        line_st,
   input logic              w_en,
   input logic              u_en,
   input logic [IDX_W-1:0]  u_idx
);
   logic peer_miss_here;
   assign peer_miss_here = (snp_id != ID_W'(MY_ID)) && ((snp_cmd == 2'd1) || (snp_cmd == 2'd2))
                           && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

   a_r9_cmd_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 2'd0) |-> bus_gnt);

   a_r9_own_id: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 2'd0) |-> (bus_id == ID_W'(MY_ID)));

   a_r10_abort_only_peer_miss: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> ((snp_id != ID_W'(MY_ID)) && ((snp_cmd == 2'd1) || (snp_cmd == 2'd2))));

   a_r8_stall_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && peer_miss_here) |-> !cpu_done);

   a_r8_single_line_writer: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && u_en) |-> (u_idx != cpu_addr[IDX_W-1:0]));

   a_r2_rdmiss_to_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd1) |=> (line_st == 2'd1));

   a_r3_wrmiss_to_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd2) |=> (line_st == 2'd2));

   a_r4_wback_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'd3) |=> bus_req);
endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_done (cpu_done),
   .cpu_addr (cpu_addr),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .bus_cmd  (bus_cmd),
   .bus_id   (bus_id),
   .snp_cmd  (snp_cmd),
   .snp_addr (snp_addr),
   .snp_id   (snp_id),
   .snp_abort(snp_abort),
   .line_st  (a_st),
   .w_en     (w_en),
   .u_en     (upd_en),
   .u_idx    (snp_idx)
);

// File: tb/sim_msi_snoop_cache.sv
module sim_msi_snoop_cache;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   localparam int IDX_W  = 2;
   localparam int ID_W   = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic              req0 = 0, we0 = 0, req1 = 0, we1 = 0;
   logic [ADDR_W-1:0] addr0 = 0, addr1 = 0;
   logic [DATA_W-1:0] wd0 = 0, wd1 = 0;
   logic              done0, done1, breq0, breq1, gnt0, gnt1, ab0, ab1;
   logic [DATA_W-1:0] rd0, rd1, bwd0, bwd1, sd0, sd1, bus_rdata, bus_wdata;
   logic [1:0]        cmd0, cmd1, bus_cmd;
   logic [ADDR_W-1:0] ba0, ba1, bus_addr;
   logic [ID_W-1:0]   id0, id1, bus_id;

   logic [DATA_W-1:0] mem [1<<ADDR_W];

   assign gnt0      = breq0;
   assign gnt1      = breq1 & ~breq0;
   assign bus_cmd   = cmd0 | cmd1;
   assign bus_addr  = ba0 | ba1;
   assign bus_wdata = bwd0 | bwd1;
   assign bus_id    = id0 | id1;
   assign bus_rdata = ab0 ? sd0 : (ab1 ? sd1 : mem[bus_addr]);

   msi_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(0)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(req0), .cpu_we(we0), .cpu_addr(addr0), .cpu_wdata(wd0),
      .cpu_done(done0), .cpu_rdata(rd0), .bus_req(breq0), .bus_gnt(gnt0), .bus_cmd(cmd0),
      .bus_addr(ba0), .bus_wdata(bwd0), .bus_id(id0), .bus_rdata(bus_rdata), .snp_cmd(bus_cmd),
      .snp_addr(bus_addr), .snp_id(bus_id), .snp_abort(ab0), .snp_data(sd0));

   msi_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(1)) u1 (
      .clk(clk), .rst_n(rst_n), .cpu_req(req1), .cpu_we(we1), .cpu_addr(addr1), .cpu_wdata(wd1),
      .cpu_done(done1), .cpu_rdata(rd1), .bus_req(breq1), .bus_gnt(gnt1), .bus_cmd(cmd1),
      .bus_addr(ba1), .bus_wdata(bwd1), .bus_id(id1), .bus_rdata(bus_rdata), .snp_cmd(bus_cmd),
      .snp_addr(bus_addr), .snp_id(bus_id), .snp_abort(ab1), .snp_data(sd1));

   // memory and bus monitor
   int n_rd [2], n_wr [2], n_wb [2], n_ab [2];
   int s_rd [2], s_wr [2], s_wb [2], s_ab [2];
   logic [ADDR_W-1:0] wb_addr;
   logic [DATA_W-1:0] wb_data;

   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_cmd == 2'd3) begin
            mem[bus_addr] <= bus_wdata;
            wb_addr       <= bus_addr;
            wb_data       <= bus_wdata;
            n_wb[bus_id]  <= n_wb[bus_id] + 1;
         end else if (ab0 || ab1) begin
            mem[bus_addr] <= ab0 ? sd0 : sd1;
         end
         if (bus_cmd == 2'd1) n_rd[bus_id] <= n_rd[bus_id] + 1;
         if (bus_cmd == 2'd2) n_wr[bus_id] <= n_wr[bus_id] + 1;
         if (ab0) n_ab[0] <= n_ab[0] + 1;
         if (ab1) n_ab[1] <= n_ab[1] + 1;
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic snap();
      for (int k = 0; k < 2; k++) begin
         s_rd[k] = n_rd[k]; s_wr[k] = n_wr[k]; s_wb[k] = n_wb[k]; s_ab[k] = n_ab[k];
      end
   endtask

   // one processor access on cache 'who'; returns read data at completion
   task automatic access(input int who, input bit we, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] r);
      @(negedge clk);
      if (who == 0) begin req0 = 1; we0 = we; addr0 = a; wd0 = d; end
      else          begin req1 = 1; we1 = we; addr1 = a; wd1 = d; end
      #1;
      while (!((who == 0) ? done0 : done1)) begin
         @(negedge clk); #1;
      end
      r = (who == 0) ? rd0 : rd1;
      @(posedge clk); #1;
      if (who == 0) req0 = 0; else req1 = 0;
      @(negedge clk);
   endtask

   localparam logic [ADDR_W-1:0] A1 = 8'h10;
   localparam logic [ADDR_W-1:0] A2 = 8'h20;

   initial begin
      #(CLK_P * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] r;
      for (int k = 0; k < (1 << ADDR_W); k++) mem[k] = '0;
      for (int k = 0; k < 2; k++) begin n_rd[k] = 0; n_wr[k] = 0; n_wb[k] = 0; n_ab[k] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1 no bus request after reset", int'(breq0 | breq1), 0);
      chk("R1 no command after reset", int'(bus_cmd), 0);

      // P1 writes 10 to A1
      snap(); access(0, 1, A1, 8'd10, r);
      chk("R1 R3 write miss from invalid", n_wr[0] - s_wr[0], 1);
      chk("R3 memory untouched by write", int'(mem[A1]), 0);
      // P1 reads A1: exclusive hit
      snap(); access(0, 0, A1, 0, r);
      chk("R2 read hit data", int'(r), 10);
      chk("R2 read hit no bus", (n_rd[0]-s_rd[0]) + (n_wr[0]-s_wr[0]), 0);
      // P2 reads A1: intervention
      snap(); access(1, 0, A1, 0, r);
      chk("R2 read miss issued", n_rd[1] - s_rd[1], 1);
      chk("R6 owner aborts", n_ab[0] - s_ab[0], 1);
      chk("R6 supplied data", int'(r), 10);
      chk("R6 memory updated", int'(mem[A1]), 10);
      snap(); access(0, 0, A1, 0, r);
      chk("R6 owner kept shared copy", (n_rd[0]-s_rd[0]) * 256 + int'(r), 10);
      // P2 writes 20 to A1
      snap(); access(1, 1, A1, 8'd20, r);
      chk("R3 write to shared is a miss", n_wr[1] - s_wr[1], 1);
      chk("R7 shared holder no abort", n_ab[0] - s_ab[0], 0);
      chk("R7 memory stale", int'(mem[A1]), 10);
      // P2 writes 40 to A2, same line
      snap(); access(1, 1, A2, 8'd40, r);
      chk("R4 write-back issued", n_wb[1] - s_wb[1], 1);
      chk("R4 write-back address", int'(wb_addr), int'(A1));
      chk("R4 write-back data", int'(mem[A1]), 20);
      chk("R4 miss follows", n_wr[1] - s_wr[1], 1);
      chk("R10 write-back causes no abort", (n_ab[0]-s_ab[0]) + (n_ab[1]-s_ab[1]), 0);
      // P1 was invalidated by the write miss
      snap(); access(0, 0, A1, 0, r);
      chk("R7 invalidated copy misses", n_rd[0] - s_rd[0], 1);
      chk("R7 fresh data", int'(r), 20);
      // P1 replaces its shared A1 with A2 held dirty by P2
      snap(); access(0, 0, A2, 0, r);
      chk("R5 clean victim no write-back", n_wb[0] - s_wb[0], 0);
      chk("R6 dirty peer supplies", (n_ab[1]-s_ab[1]) * 256 + int'(r), 256 + 40);

      // sweep every line index
      for (int i = 0; i < (1 << IDX_W); i++) begin
         logic [ADDR_W-1:0] a;
         int v;
         a = ADDR_W'(5 * (1 << IDX_W) + i);
         v = i * 9 + 7;
         snap(); access(0, 1, a, DATA_W'(v), r);
         chk("R3 sweep write miss", n_wr[0] - s_wr[0], 1);
         chk("R5 sweep no write-back", n_wb[0] - s_wb[0], 0);
         snap(); access(1, 0, a, 0, r);
         chk("R6 sweep read data", int'(r), v);
         chk("R6 sweep abort", n_ab[0] - s_ab[0], 1);
         snap(); access(1, 1, a, DATA_W'(v + 1), r);
         chk("R7 sweep shared invalidate no abort", n_ab[0] - s_ab[0], 0);
         snap(); access(0, 0, a, 0, r);
         chk("R7 sweep re-read", int'(r), v + 1);
         chk("R7 sweep dirty peer aborts", n_ab[1] - s_ab[1], 1);
         chk("R10 sweep requester never aborts own", n_ab[0] - s_ab[0], 0);
      end

      // snoop priority: cache 1 write-misses index 1 while cache 0 reads it
      @(negedge clk);
      req1 = 1; we1 = 1; addr1 = ADDR_W'(5 * (1 << IDX_W) + 1); wd1 = 8'd99;
      @(negedge clk);
      req0 = 1; we0 = 0; addr0 = ADDR_W'(5 * (1 << IDX_W) + 1);
      #1;
      chk("R8 read stalled during peer miss", int'(done0), 0);
      chk("R9 peer command on bus", int'(bus_cmd), 2);
      chk("R9 peer id on bus", int'(bus_id), 1);
      while (!done1) begin @(negedge clk); #1; end
      @(posedge clk); #1; req1 = 0;
      while (!done0) begin @(negedge clk); #1; end
      chk("R8 retried read sees new data", int'(rd0), 99);
      @(posedge clk); #1; req0 = 0;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule